// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Word Assembler

This block gathers an already-sampled serial bit stream, one bit per cycle in which `bit_en` is high, into parallel words. With `narrow` low, each word is 20 bits wide. With `narrow` high, each word is 10 bits wide. Completed words are announced by `word_stb`, a one-cycle enable that marks the falling edge of the divided word clock. `data_out` and `sync_out` change only together with that strobe.

While it collects bits, the block also looks for a comma character of 8b/10b-coded traffic. The block treats a character as a comma when its first seven bits, in arrival order, are 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0. Finding a comma abandons the word in progress and moves the word boundary, so that the comma ends up in a fixed lane. The word that carries the comma is flagged by `sync_out`, which stays high for that single word period. In 10-bit mode the low half of the bus is tied high. A rising edge on `narrow` restarts the bit counter.

Top module: `comma_deser`

## Requirements
- R1: With `narrow` low, one `word_stb` follows every 20 accepted bits. In that word, `data_out[0]` holds the earliest bit and `data_out[19]` the latest.
- R2: With `narrow` high, one `word_stb` follows every 10 accepted bits. `data_out[10]` holds the earliest bit, `data_out[19]` the latest, and `data_out[9:0]` reads all ones.
- R3: `word_stb` is high in the cycle after the edge that accepted the word's last bit. `data_out` changes only in a cycle where `word_stb` is high, or when `narrow` changes.
- R4: A comma is recognised when the most recent 10 accepted bits begin, in arrival order, with 0011111 or 1100000. Recognition only happens once at least 10 bits have been accepted since reset.
- R5: In 20-bit mode, no strobe occurs on the bit that completes a comma. The next strobe comes exactly 10 accepted bits later, and any boundary from the old alignment in between is dropped. That word carries the comma in `data_out[9:0]` and has `sync_out` high.
- R6: In 10-bit mode, the strobe occurs on the bit that completes the comma. That word carries the comma in `data_out[19:10]` and has `sync_out` high.
- R7: After a realignment, strobes continue at the regular spacing counted from the new boundary.
- R8: `sync_out` rises only with a comma word. It stays high for exactly one word period and falls at the next strobe whose word holds no comma.
- R9: After reset and before the first comma, boundaries fall every word width counted from the first accepted bit, and `sync_out` stays low.
- R10: A comma that already lies on the current boundary causes no shift in strobe timing but still raises `sync_out`.
- R11: A rising edge of `narrow` restarts the bit count, so the next word ends after a full word width.
- R12: Cycles with `bit_en` low accept no bit, advance no count and produce no strobe.
- R13: During and just after reset, `word_stb` and `sync_out` are low and the word register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Accept `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit |
| narrow | input | 1 | Width select: 1 = 10-bit words, 0 = 20-bit words |
| word_stb | output | 1 | One-cycle word clock enable (falling edge of word clock) |
| data_out | output | 20 | Parallel word |
| sync_out | output | 1 | Comma word flag, one word period long |

## Verification
The hardest condition to create is a comma that arrives off the current boundary: the comma straddles an old boundary, and that boundary has to vanish rather than produce a strobe. The stimulus therefore walks a set of scenarios. Each scenario places a comma of either polarity after a chosen number of alternating filler bits, so that the comma sits on, just before, straddling, or a full word after a boundary in both widths. Idle cycles are mixed in to show that gaps in `bit_en` do not shift the count. A separate sequence switches the width mid-word to exercise the counter restart.

// File: rtl/comma_deser.sv
`timescale 1ns/1ps
module comma_deser #(
  parameter int CW = 10,
  parameter logic [6:0] COMMA = 7'b1111100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          narrow,
  output logic          word_stb,
  output logic [2*CW-1:0] data_out,
  output logic          sync_out
);
  localparam int WW    = 2 * CW;
  localparam int CNT_W = $clog2(WW);
  localparam int FIL_W = $clog2(CW);

  logic [WW-1:0]    sr, word_q;
  logic [CNT_W-1:0] cnt;
  logic [FIL_W-1:0] fill;
  logic             narrow_q, pend;

  wire [WW-1:0]    nxt     = {bit_in, sr[WW-1:1]};
  wire [6:0]       win     = nxt[CW+6:CW];
  wire             primed  = (fill == FIL_W'(CW - 1));
  wire             comma   = bit_en && primed && (win == COMMA || win == ~COMMA);
  wire [CNT_W-1:0] last    = narrow ? CNT_W'(CW - 1) : CNT_W'(WW - 1);
  wire             full    = bit_en && (cnt == last);
  wire             restart = narrow && !narrow_q;

  assign data_out = narrow ? {word_q[WW-1:CW], {CW{1'b1}}} : word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      word_q   <= '0;
      cnt      <= '0;
      fill     <= '0;
      narrow_q <= 1'b1;
      pend     <= 1'b0;
      word_stb <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      narrow_q <= narrow;
      word_stb <= 1'b0;
      if (bit_en) begin
        sr <= nxt;
        if (!primed) fill <= fill + 1'b1;
      end
      if (restart) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else if (comma && narrow) begin
        cnt      <= '0;
        word_stb <= 1'b1;
        word_q   <= nxt;
        sync_out <= 1'b1;
        pend     <= 1'b0;
      end else if (comma) begin
        cnt  <= CNT_W'(CW);
        pend <= 1'b1;
      end else if (full) begin
        cnt      <= '0;
        word_stb <= 1'b1;
        word_q   <= nxt;
        sync_out <= pend;
        pend     <= 1'b0;
      end else if (bit_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/comma_deser_chk.sv
`timescale 1ns/1ps
module comma_deser_chk #(
  parameter int CW = 10,
  parameter logic [6:0] COMMA = 7'b1111100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          narrow,
  input logic          word_stb,
  input logic [2*CW-1:0] data_out,
  input logic          sync_out
);
  assert_data_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> (word_stb || !$stable(narrow)));

  assert_sync_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_out) |-> word_stb);

  assert_strobe_needs_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(bit_en));

  assert_wide_comma_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && sync_out && !narrow) |->
      (data_out[6:0] == COMMA || data_out[6:0] == ~COMMA));

  assert_narrow_comma_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && sync_out && narrow) |->
      (data_out[CW+6:CW] == COMMA || data_out[CW+6:CW] == ~COMMA));
endmodule

bind comma_deser comma_deser_chk #(.CW(CW), .COMMA(COMMA)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .narrow(narrow),
  .word_stb(word_stb), .data_out(data_out), .sync_out(sync_out));

// File: tb/tb_comma_deser.sv
`timescale 1ns/1ps
module tb_comma_deser;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, narrow = 1'b0;
  logic word_stb, sync_out;
  logic [19:0] data_out;

  comma_deser dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .narrow(narrow), .word_stb(word_stb), .data_out(data_out), .sync_out(sync_out));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 1'b0;

  // Scenario table: {narrow, comma polarity, filler bits before comma}
  localparam logic [6:0] VEC [8] = '{
    {1'b0, 1'b0, 5'd0}, {1'b0, 1'b1, 5'd3}, {1'b0, 1'b0, 5'd10}, {1'b0, 1'b1, 5'd19},
    {1'b0, 1'b0, 5'd20}, {1'b1, 1'b1, 5'd0}, {1'b1, 1'b0, 5'd4}, {1'b1, 1'b1, 5'd9}};
  localparam logic [9:0] K_NEG = 10'h17C;
  localparam logic [9:0] K_POS = 10'h283;
  localparam logic [9:0] FILL  = 10'h2AA;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic nar);
    rst_n = 1'b0; bit_en = 1'b0; narrow = nar;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_en = 1'b1;
    @(posedge clk);
    #1 bit_en = 1'b0;
  endtask

  task automatic idle(input int n, inout int strobes);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 strobes += int'(word_stb);
    end
  endtask

  initial begin
    #900us;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int stbs, idle_stb, syn_drop;
    logic syn;
    logic [9:0] kch;
    int pre, wid;
    logic nar;

    // R13: reset state
    rst_n = 1'b0; narrow = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(word_stb == 1'b0 && sync_out == 1'b0, "R13 strobe/sync in reset",
          32'({word_stb, sync_out}), 32'h0);
    check(data_out == 20'h0, "R13 word zero", 32'(data_out), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(word_stb == 1'b0 && sync_out == 1'b0, "R13 after release",
          32'({word_stb, sync_out}), 32'h0);

    // R1 R9: 20-bit packing, earliest bit in bit 0, no sync
    stbs = 0; syn = 1'b0;
    for (int i = 0; i < 19; i++) begin
      send_bit(1'(20'h6D2B4 >> i));
      stbs += int'(word_stb); syn |= sync_out;
    end
    check(stbs == 0, "R1 no early strobe", 32'(stbs), 32'd0);
    send_bit(1'(20'h6D2B4 >> 19));
    check(word_stb == 1'b1, "R1 strobe at bit 20", 32'(word_stb), 32'd1);
    check(data_out == 20'h6D2B4, "R1 bit order", 32'(data_out), 32'h6D2B4);
    check(!syn && !sync_out, "R9 sync low before comma", 32'(sync_out), 32'd0);

    // Table walk: comma placement in both widths (R4 both polarities, R10 on pre 0 / 20)
    for (int e = 0; e < 8; e++) begin
      nar = VEC[e][6];
      kch = VEC[e][5] ? K_POS : K_NEG;
      pre = int'(VEC[e][4:0]);
      wid = nar ? 10 : 20;
      apply_reset(nar);
      stbs = 0; syn = 1'b0; idle_stb = 0;
      for (int i = 0; i < pre; i++) begin
        send_bit(1'(i % 2));
        stbs += int'(word_stb); syn |= sync_out;
      end
      idle(2, idle_stb);
      check(idle_stb == 0, "R12 no strobe while idle", 32'(idle_stb), 32'd0);
      for (int i = 0; i < 9; i++) begin
        send_bit(kch[i]);
        stbs += int'(word_stb); syn |= sync_out;
      end
      check(stbs == (pre + 9) / wid, "R9 boundaries from reset",
            32'(stbs), 32'((pre + 9) / wid));
      check(!syn, "R9 sync low before comma", 32'(syn), 32'd0);
      send_bit(kch[9]);
      if (nar) begin
        check(word_stb == 1'b1, "R6 strobe on comma end", 32'(word_stb), 32'd1);
        check(data_out[19:10] == kch, "R4 R6 comma in upper lane",
              32'(data_out[19:10]), 32'(kch));
        check(data_out[9:0] == 10'h3FF, "R2 lower half high",
              32'(data_out[9:0]), 32'h3FF);
        check(sync_out == 1'b1, "R6 R10 sync with comma", 32'(sync_out), 32'd1);
      end else begin
        check(word_stb == 1'b0, "R5 no strobe on comma end", 32'(word_stb), 32'd0);
      end
      stbs = 0; syn_drop = 0;
      for (int i = 0; i < 9; i++) begin
        send_bit(FILL[i]);
        stbs += int'(word_stb);
        if (nar && !sync_out) syn_drop++;
      end
      check(stbs == 0, "R5 R7 old boundary dropped", 32'(stbs), 32'd0);
      check(syn_drop == 0, "R8 sync held for word period", 32'(syn_drop), 32'd0);
      send_bit(FILL[9]);
      check(word_stb == 1'b1, "R5 R7 strobe at new boundary", 32'(word_stb), 32'd1);
      if (nar) begin
        check(data_out == {FILL, 10'h3FF}, "R2 R7 next narrow word",
              32'(data_out), 32'({FILL, 10'h3FF}));
        check(sync_out == 1'b0, "R8 sync falls", 32'(sync_out), 32'd0);
      end else begin
        check(data_out == {FILL, kch}, "R4 R5 comma in lower lane",
              32'(data_out), 32'({FILL, kch}));
        check(sync_out == 1'b1, "R5 R10 sync with comma", 32'(sync_out), 32'd1);
        stbs = 0; syn_drop = 0;
        for (int j = 0; j < 19; j++) begin
          send_bit(FILL[j % 10]);
          stbs += int'(word_stb);
          if (!sync_out) syn_drop++;
        end
        check(stbs == 0 && syn_drop == 0, "R7 R8 gap after comma word",
              32'({stbs[15:0], syn_drop[15:0]}), 32'h0);
        send_bit(FILL[9]);
        check(word_stb == 1'b1, "R7 regular spacing", 32'(word_stb), 32'd1);
        check(data_out == {FILL, FILL}, "R1 R7 next wide word",
              32'(data_out), 32'({FILL, FILL}));
        check(sync_out == 1'b0, "R8 sync falls", 32'(sync_out), 32'd0);
      end
    end

    // R11: rising edge of width select restarts the count
    apply_reset(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'(i % 2));
    narrow = 1'b1;
    idle_stb = 0;
    idle(1, idle_stb);
    stbs = 0;
    for (int i = 0; i < 9; i++) begin
      send_bit(FILL[i]);
      stbs += int'(word_stb);
    end
    check(stbs == 0, "R11 no strobe before full narrow word", 32'(stbs), 32'd0);
    send_bit(FILL[9]);
    check(word_stb == 1'b1, "R11 strobe after 10 bits", 32'(word_stb), 32'd1);
    check(data_out == {FILL, 10'h3FF}, "R2 R11 narrow word",
          32'(data_out), 32'({FILL, 10'h3FF}));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule